// File: doc/BRIEF.md
# Serial Receive Data Buffer with Debug Peek

This block sits between a serial receive shift register and a 32-bit register bus. When the upstream framer signals that a character is complete, the block captures the character bits and raises a ready flag. If the receive interrupt is enabled, it also drives an interrupt. Characters shorter than the full byte are stored against the top of the byte, and the vacant low bits are zero. Software must shift the value right to recover the character.

Software reaches the same stored byte through two read-only bus locations. A read of the consuming location returns the byte and clears the ready flag. A read of the peek location returns the same byte and has no side effect, so a debugger can watch the buffer without disturbing the receive flow. A second frame that lands while the ready flag is still set overwrites the buffer and sets an overrun flag. The buffer and both data locations work only when the plain serial mode input is high.

Top module: `serial_rx_peek_buf`

## Requirements
- R1: After reset, rx_ready, rx_overrun and rx_irq are 0, and the stored byte reads as 0x00.
- R2: When frame_done is high at a clock edge and serial_mode is high, the justified character is in the buffer and rx_ready is 1 from the following cycle.
- R3: char_len value n (0 to 7) selects a character of n+1 bits, taken from frame_bits[n:0]. The character is stored in byte bits 7 down to 7-n, and the bits below are 0. For example, n=2 with frame_bits=3'b101 stores 0xA0.
- R4: A bus read (bus_rd=1) of offset 0x34 returns the stored byte on bus_rdata[7:0] in the same cycle, and clears rx_ready in the next cycle.
- R5: A bus read of offset 0x30 returns the stored byte on bus_rdata[7:0] and leaves rx_ready, rx_overrun and the byte unchanged.
- R6: bus_rdata[31:8] is always 0. bus_rdata is 0 when bus_rd is low or the offset is neither 0x30 nor 0x34. Bus writes (bus_wr) to any offset change no state.
- R7: While serial_mode is low, bus_rdata is 0, reads have no side effect, and frame_done is ignored.
- R8: rx_irq is high exactly when rx_ready and rx_int_en are both high, at the same time.
- R9: If a consuming read and an accepted frame occur in the same cycle, the new byte is stored, rx_ready stays 1, and rx_overrun does not change.
- R10: A frame accepted while rx_ready is 1, with no consuming read in that cycle, overwrites the byte and sets rx_overrun. A consuming read without a frame clears rx_overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode | input | 1 | High selects the plain serial mode in which the buffer works |
| frame_done | input | 1 | One-cycle strobe: a character is complete |
| frame_bits | input | 8 | Character bits, LSB-first, packed low |
| char_len | input | 3 | Character length minus one |
| rx_int_en | input | 1 | Receive interrupt enable |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe (has no effect) |
| bus_addr | input | 8 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data (ignored) |
| bus_rdata | output | 32 | Bus read data |
| rx_ready | output | 1 | A character is waiting to be consumed |
| rx_overrun | output | 1 | A character was overwritten before it was consumed |
| rx_irq | output | 1 | Level receive interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit character, a 32-bit bus, offsets 0x30 and 0x34, and the combinational interrupt variant. The 3-bit length field therefore covers all eight justification shifts, from a 1-bit character to a full byte. R8 can be checked in the same cycle because the interrupt variant is combinational. Directed sequences drive a read and a frame in the same cycle, an overrun followed by recovery, and mode-off traffic. A long random run follows them, and a behavioural model checks every output on every clock.

// File: rtl/srpb_pkg.sv
package srpb_pkg;
   localparam int unsigned SRPB_BUS_W   = 32;
   localparam int unsigned SRPB_ADDR_W  = 8;
   localparam logic [7:0]  SRPB_PEEK_OFS = 8'h30;
   localparam logic [7:0]  SRPB_TAKE_OFS = 8'h34;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_PEEK = 2'd1,
      ACC_TAKE = 2'd2
   } srpb_acc_e;
endpackage

// File: rtl/srpb_justify.sv
module srpb_justify #(
   parameter int unsigned CHAR_W = 8,
   localparam int unsigned LEN_W = $clog2(CHAR_W)
) (
   input  logic [CHAR_W-1:0] raw_bits,
   input  logic [LEN_W-1:0]  len_code,
   output logic [CHAR_W-1:0] just_bits
);
   logic [CHAR_W-1:0] cand [CHAR_W];

   // one candidate per length: keep bits k..0, move them to the top
   for (genvar k = 0; k < CHAR_W; k++) begin : g_len
      if (k == CHAR_W - 1) begin : g_full
         assign cand[k] = raw_bits;
      end else begin : g_short
         assign cand[k] = {raw_bits[k:0], {(CHAR_W-1-k){1'b0}}};
      end
   end

   always_comb begin
      if (32'(len_code) < CHAR_W) just_bits = cand[len_code];
      else                        just_bits = cand[CHAR_W-1];
   end
endmodule

// File: rtl/srpb_store.sv
module srpb_store #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic [CHAR_W-1:0] din,
   output logic [CHAR_W-1:0] data_q,
   output logic              ready_q,
   output logic              ovr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (load) data_q <= din;
         // a new frame wins over a consuming read
         if (load)      ready_q <= 1'b1;
         else if (take) ready_q <= 1'b0;
         if (load && ready_q && !take) ovr_q <= 1'b1;
         else if (take && !load)       ovr_q <= 1'b0;
      end
   end
endmodule

// File: rtl/srpb_rdmux.sv
module srpb_rdmux
   import srpb_pkg::*;
#(
   parameter int unsigned CHAR_W   = 8,
   parameter int unsigned BUS_W    = SRPB_BUS_W,
   parameter int unsigned ADDR_W   = SRPB_ADDR_W,
   parameter logic [ADDR_W-1:0] PEEK_OFS = ADDR_W'(SRPB_PEEK_OFS),
   parameter logic [ADDR_W-1:0] TAKE_OFS = ADDR_W'(SRPB_TAKE_OFS)
) (
   input  logic              rd,
   input  logic              mode_on,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CHAR_W-1:0] data,
   output srpb_acc_e         acc,
   output logic [BUS_W-1:0]  rdata
);
   localparam int unsigned PAD_W = BUS_W - CHAR_W;

   always_comb begin
      acc = ACC_NONE;
      if (rd && mode_on) begin
         if (addr == TAKE_OFS)      acc = ACC_TAKE;
         else if (addr == PEEK_OFS) acc = ACC_PEEK;
      end
   end

   assign rdata = (acc != ACC_NONE) ? {{PAD_W{1'b0}}, data} : '0;
endmodule

// File: rtl/srpb_irq.sv
module srpb_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic enable,
   output logic irq
);
   if (IRQ_REG) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= ready & enable;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = ready & enable;
   end
endmodule

// File: rtl/serial_rx_peek_buf.sv
module serial_rx_peek_buf
   import srpb_pkg::*;
#(
   parameter int unsigned CHAR_W   = 8,
   parameter int unsigned BUS_W    = SRPB_BUS_W,
   parameter int unsigned ADDR_W   = SRPB_ADDR_W,
   parameter logic [ADDR_W-1:0] PEEK_OFS = ADDR_W'(SRPB_PEEK_OFS),
   parameter logic [ADDR_W-1:0] TAKE_OFS = ADDR_W'(SRPB_TAKE_OFS),
   parameter bit IRQ_REG = 1'b0,
   localparam int unsigned LEN_W = $clog2(CHAR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              serial_mode,
   input  logic              frame_done,
   input  logic [CHAR_W-1:0] frame_bits,
   input  logic [LEN_W-1:0]  char_len,
   input  logic              rx_int_en,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              rx_ready,
   output logic              rx_overrun,
   output logic              rx_irq
);
   if (CHAR_W < 2 || (1 << LEN_W) != CHAR_W) begin : g_bad_char
      $error("CHAR_W must be a power of two of at least 2");
   end
   if (BUS_W < CHAR_W) begin : g_bad_bus
      $error("BUS_W must hold a full character");
   end
   if (PEEK_OFS == TAKE_OFS) begin : g_bad_ofs
      $error("peek and consume offsets must differ");
   end

   logic [CHAR_W-1:0] just_bits;
   logic [CHAR_W-1:0] data_q;
   srpb_acc_e         acc;
   logic              load;
   logic              take;
   logic              unused_wr;

   assign load = frame_done & serial_mode;
   assign take = (acc == ACC_TAKE);
   assign unused_wr = bus_wr ^ (^bus_wdata);

   srpb_justify #(.CHAR_W(CHAR_W)) u_just (
      .raw_bits (frame_bits),
      .len_code (char_len),
      .just_bits(just_bits)
   );

   srpb_store #(.CHAR_W(CHAR_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .take   (take),
      .din    (just_bits),
      .data_q (data_q),
      .ready_q(rx_ready),
      .ovr_q  (rx_overrun)
   );

   srpb_rdmux #(
      .CHAR_W(CHAR_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
      .PEEK_OFS(PEEK_OFS), .TAKE_OFS(TAKE_OFS)
   ) u_rdmux (
      .rd     (bus_rd),
      .mode_on(serial_mode),
      .addr   (bus_addr),
      .data   (data_q),
      .acc    (acc),
      .rdata  (bus_rdata)
   );

   srpb_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (rx_ready),
      .enable(rx_int_en),
      .irq   (rx_irq)
   );
endmodule

// File: rtl/srpb_checker.sv
module srpb_checker #(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CHAR_W = 8,
   parameter logic [ADDR_W-1:0] PEEK_OFS = '0,
   parameter logic [ADDR_W-1:0] TAKE_OFS = '0,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              serial_mode,
   input logic              frame_done,
   input logic              rx_int_en,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              rx_ready,
   input logic              rx_overrun,
   input logic              rx_irq
);
   logic take_rd, peek_rd;
   assign take_rd = bus_rd && serial_mode && (bus_addr == TAKE_OFS);
   assign peek_rd = bus_rd && serial_mode && (bus_addr == PEEK_OFS);

   p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && serial_mode) |=> rx_ready);

   p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_rd && !frame_done) |=> !rx_ready);

   p_peek_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (peek_rd && !frame_done) |=> ($stable(rx_ready) && $stable(rx_overrun)));

   p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_W-1:CHAR_W] == '0);

   p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !serial_mode |=> ($stable(rx_ready) && $stable(rx_overrun)));

   p_mode_off_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !serial_mode |-> (bus_rdata == '0));

   p_collide_keeps_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_rd && frame_done) |=> (rx_ready && $stable(rx_overrun)));

   p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && serial_mode && rx_ready && !take_rd) |=> rx_overrun);

   if (!IRQ_REG) begin : g_irq_chk
      p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_ready |-> !rx_irq);
      p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_ready && rx_int_en) |-> rx_irq);
   end
endmodule

bind serial_rx_peek_buf srpb_checker #(
   .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W),
   .PEEK_OFS(PEEK_OFS), .TAKE_OFS(TAKE_OFS), .IRQ_REG(IRQ_REG)
) u_srpb_chk (
   .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
   .frame_done(frame_done), .rx_int_en(rx_int_en), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
   .rx_overrun(rx_overrun), .rx_irq(rx_irq)
);

// File: tb/test_serial_rx_peek_buf.sv
`timescale 1ns/1ps
module test_serial_rx_peek_buf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        serial_mode = 1'b1;
   logic        frame_done = 1'b0;
   logic [7:0]  frame_bits = '0;
   logic [2:0]  char_len = 3'd7;
   logic        rx_int_en = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_ready, rx_overrun, rx_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   int m_data = 0;
   int m_ready = 0;
   int m_ovr = 0;

   always #2.5 clk = ~clk;

   serial_rx_peek_buf i_serial_rx_peek_buf (
      .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
      .frame_done(frame_done), .frame_bits(frame_bits), .char_len(char_len),
      .rx_int_en(rx_int_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_irq(rx_irq)
   );

   function automatic int model_just(int bits, int code);
      int n = code + 1;
      int keep = bits % (1 << n);
      return (keep * (1 << (8 - n))) % 256;
   endfunction

   always @(posedge clk) begin
      int is_take, is_load;
      if (!rst_n) begin
         m_data = 0; m_ready = 0; m_ovr = 0;
      end else begin
         is_take = (bus_rd && serial_mode && bus_addr == 8'h34) ? 1 : 0;
         is_load = (frame_done && serial_mode) ? 1 : 0;
         if (is_load == 1) begin
            if (m_ready == 1 && is_take == 0) m_ovr = 1;
            m_data = model_just(int'(frame_bits), int'(char_len));
            m_ready = 1;
         end else if (is_take == 1) begin
            m_ready = 0;
            m_ovr = 0;
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_rdata();
      if (bus_rd && serial_mode && (bus_addr == 8'h30 || bus_addr == 8'h34))
         return m_data;
      return 0;
   endfunction

   // compare every output against the model
   task automatic compare_all();
      check("R4/R5/R6/R7 rdata", int'(bus_rdata), exp_rdata());
      check("R2/R4/R9 ready", int'(rx_ready), m_ready);
      check("R10 overrun", int'(rx_overrun), m_ovr);
      check("R8 irq", int'(rx_irq), (m_ready == 1 && rx_int_en) ? 1 : 0);
   endtask

   // one cycle: compare at the falling edge, then drive new inputs
   task automatic cyc(bit fd, int bits, int len, bit rd, int addr, bit wr);
      @(negedge clk);
      compare_all();
      frame_done = fd; frame_bits = 8'(bits); char_len = 3'(len);
      bus_rd = rd; bus_addr = 8'(addr); bus_wr = wr;
      bus_wdata = wr ? $urandom : 32'h0;
   endtask

   task automatic peek_expect(int exp, string tag);
      @(negedge clk);
      compare_all();
      frame_done = 0; bus_wr = 0; bus_rd = 1; bus_addr = 8'h30;
      #1;
      check(tag, int'(bus_rdata), exp);
   endtask

   initial begin
      repeat (3) cyc(0, 0, 7, 0, 0, 0);
      @(negedge clk);
      check("R1 ready", int'(rx_ready), 0);
      check("R1 overrun", int'(rx_overrun), 0);
      check("R1 irq", int'(rx_irq), 0);
      rst_n = 1;
      peek_expect(0, "R1 data");
      // R3: 3-bit character 101 -> A0
      cyc(1, 8'hFD, 2, 0, 0, 0);
      peek_expect(8'hA0, "R3 len3");
      cyc(1, 8'h01, 0, 0, 0, 0);
      peek_expect(8'h80, "R3 len1");
      cyc(1, 8'h5A, 7, 0, 0, 0);
      peek_expect(8'h5A, "R3 len8");
      // R5: repeated peeks keep ready
      repeat (3) cyc(0, 0, 7, 1, 8'h30, 0);
      rx_int_en = 1;
      cyc(0, 0, 7, 0, 0, 0);
      check("R8 irq on", int'(rx_irq), 1);
      // R6: writes and other offsets
      cyc(0, 0, 7, 0, 8'h34, 1);
      cyc(0, 0, 7, 0, 8'h30, 1);
      cyc(0, 0, 7, 1, 8'h38, 0);
      peek_expect(8'h5A, "R6 write ignored");
      // R4: consume
      cyc(0, 0, 7, 1, 8'h34, 0);
      cyc(0, 0, 7, 0, 0, 0);
      check("R4 ready cleared", int'(rx_ready), 0);
      // R10: overrun
      cyc(1, 8'h11, 7, 0, 0, 0);
      cyc(1, 8'h22, 7, 0, 0, 0);
      cyc(0, 0, 7, 0, 0, 0);
      check("R10 overrun set", int'(rx_overrun), 1);
      // R9: read and frame together
      cyc(1, 8'h33, 7, 1, 8'h34, 0);
      cyc(0, 0, 7, 0, 0, 0);
      check("R9 ready kept", int'(rx_ready), 1);
      check("R9 overrun kept", int'(rx_overrun), 1);
      peek_expect(8'h33, "R9 new data");
      cyc(0, 0, 7, 1, 8'h34, 0);
      cyc(0, 0, 7, 0, 0, 0);
      check("R10 overrun cleared", int'(rx_overrun), 0);
      // R7: mode off
      cyc(1, 8'h44, 7, 0, 0, 0);
      @(negedge clk);
      serial_mode = 0;
      cyc(1, 8'h77, 7, 1, 8'h34, 0);
      cyc(0, 0, 7, 1, 8'h30, 0);
      #1 check("R7 read zero", int'(bus_rdata), 0);
      cyc(0, 0, 7, 0, 0, 0);
      serial_mode = 1;
      peek_expect(8'h44, "R7 frame ignored");
      check("R7 ready kept", int'(rx_ready), 1);
      // random run
      for (int i = 0; i < 3000; i++) begin
         int a;
         a = ($urandom % 4 == 0) ? 8'h30 : (($urandom % 3 == 0) ? 8'h34 : $urandom % 256);
         rx_int_en = ($urandom % 2 == 1);
         if ($urandom % 16 == 0) serial_mode = ~serial_mode;
         cyc($urandom % 3 == 0, $urandom % 256, $urandom % 8,
             $urandom % 2 == 1, a, $urandom % 5 == 0);
      end
      cyc(0, 0, 7, 0, 0, 0);
      @(negedge clk);
      compare_all();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule